// File: doc/BRIEF.md
# Pixel Auto-Step Write Port

This block lets software stream pixels into a frame buffer without reprogramming the address between pixels. Software first loads a linear destination address, a per-lane pixel mask, a line stride and an access mode. Every write to one of eight data registers then stores one pixel, or one word of pixels, and moves the address. The register that was written selects the compass direction of the move: horizontal steps add or subtract one address unit, and vertical steps add or subtract the stride.

The access mode sets the address unit. In byte mode the address counts bytes. The written pixel is the low byte of the data, placed on the lane picked by the low address bits. In word mode the address counts whole memory words and the full data word is written under the mask. Each data write produces one registered write cycle on a simple synchronous memory port with byte enables. The address wraps silently at the end of the frame buffer.

Top module: `pixstep_port`

## Requirements
- R1: After reset the memory port is idle, the mask is all ones (4'b1111), the mode is byte mode, the stride is zero and the destination address is zero.
- R2: A register write to an address in the range 8..15 (a data register) causes exactly one cycle with memWrEn high, on the clock edge after the write. No other register write produces a memory cycle.
- R3: The mode register is at address 2, and bit 0 set selects word mode. In word mode the memory cycle carries the current address (its low 8 bits) as memAddr, the full write data, and the mask register (address 1, bits 3:0, one bit per byte lane) as byte enables.
- R4: In byte mode, memAddr is the address shifted right by 2 and the lane is address bits 1:0. Data byte 7:0 is replicated onto all four lanes. The byte enables are the one-hot lane bit ANDed with the mask.
- R5: Data register 8 (right) adds one address unit after the write, and register 9 (left) subtracts one.
- R6: Data register 10 (down) adds the stride (address 3, bits 9:0), and register 11 (up) subtracts it.
- R7: The diagonal registers move in both axes at once: 12 adds 1 and the stride, 13 subtracts 1 and adds the stride, 14 adds 1 and subtracts the stride, 15 subtracts 1 and the stride.
- R8: Stepping wraps with no fault. In byte mode the wrap is modulo 1024. In word mode the wrap is modulo 256, and bits 9:8 of the address are cleared.
- R9: The address update takes effect before the next write, so data writes on back-to-back cycles go to consecutive stepped locations.
- R10: Writes to the unused addresses 4..7 have no effect on any register and produce no memory cycle. The destination address register is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| memWrEn | output | 1 | Memory write cycle |
| memAddr | output | 8 | Memory word address |
| memWrData | output | 32 | Memory write data |
| memByteEn | output | 4 | Memory byte enables |

## Verification
Directed sequences walk each of the eight directions from a known address, in both byte and word mode. This separates a wrong sign or a wrong axis per direction, and lane selection from whole-word enables. Wrap cases at the top and bottom of both address ranges separate modulo arithmetic from saturation or a leftover high bit. Random mixes of configuration writes, data writes, idle cycles and unused-address writes, issued back to back, show whether an update lands before the following write and whether stray registers are touched. A final comparison of the whole memory image catches any misplaced byte.

// File: rtl/pixstep_pkg.sv
package pixstep_pkg;

  typedef enum logic [2:0] {
    DIR_R  = 3'd0,
    DIR_L  = 3'd1,
    DIR_D  = 3'd2,
    DIR_U  = 3'd3,
    DIR_DR = 3'd4,
    DIR_DL = 3'd5,
    DIR_UR = 3'd6,
    DIR_UL = 3'd7
  } stepDir_e;

  typedef struct packed {
    logic     ldDest;
    logic     ldMask;
    logic     ldMode;
    logic     ldStride;
    logic     pixWr;
    stepDir_e dir;
  } ctrlStrobe_t;

  // {move, negative} for the horizontal axis
  function automatic logic [1:0] xMove(stepDir_e d);
    case (d)
      DIR_R, DIR_DR, DIR_UR: xMove = 2'b10;
      DIR_L, DIR_DL, DIR_UL: xMove = 2'b11;
      default:               xMove = 2'b00;
    endcase
  endfunction

  // {move, negative} for the vertical axis
  function automatic logic [1:0] yMove(stepDir_e d);
    case (d)
      DIR_D, DIR_DR, DIR_DL: yMove = 2'b10;
      DIR_U, DIR_UR, DIR_UL: yMove = 2'b11;
      default:               yMove = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/pixstep_ctrl.sv
module pixstep_ctrl
  import pixstep_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output ctrlStrobe_t       strobe
);

  logic cfgHit;
  logic dataHit;

  assign dataHit = regWrEn && regAddr[REG_AW-1];
  assign cfgHit  = regWrEn && (regAddr[REG_AW-1:2] == '0);

  always_comb begin
    strobe          = '0;
    strobe.pixWr    = dataHit;
    strobe.dir      = stepDir_e'(regAddr[2:0]);
    strobe.ldDest   = cfgHit && (regAddr[1:0] == 2'd0);
    strobe.ldMask   = cfgHit && (regAddr[1:0] == 2'd1);
    strobe.ldMode   = cfgHit && (regAddr[1:0] == 2'd2);
    strobe.ldStride = cfgHit && (regAddr[1:0] == 2'd3);
  end

endmodule

// File: rtl/pixstep_dp.sv
module pixstep_dp
  import pixstep_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [DATA_W-1:0]      regWrData,
  output logic                   memWrEn,
  output logic [WADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]      memWrData,
  output logic [DATA_W/8-1:0]    memByteEn
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int ADDR_W = WADDR_W + LANE_W;

  logic [ADDR_W-1:0]  destAddr;
  logic [ADDR_W-1:0]  stride;
  logic [LANES-1:0]   pixMask;
  logic               wordMode;

  logic [1:0]         xm, ym;
  logic [ADDR_W-1:0]  xTerm, yTerm, unitMask, nextAddr;
  logic [WADDR_W-1:0] wrWordAddr;
  logic [DATA_W-1:0]  wrData;
  logic [LANES-1:0]   wrBe;
  logic [LANES-1:0]   laneSel;

  always_comb begin
    xm       = xMove(strobe.dir);
    ym       = yMove(strobe.dir);
    xTerm    = xm[1] ? (xm[0] ? '1 : ADDR_W'(1)) : '0;
    yTerm    = ym[1] ? (ym[0] ? ('0 - stride) : stride) : '0;
    unitMask = wordMode ? {{LANE_W{1'b0}}, {WADDR_W{1'b1}}} : '1;
    nextAddr = (destAddr + xTerm + yTerm) & unitMask;
    laneSel  = LANES'(1) << destAddr[LANE_W-1:0];
    if (wordMode) begin
      wrWordAddr = destAddr[WADDR_W-1:0];
      wrData     = regWrData;
      wrBe       = pixMask;
    end else begin
      wrWordAddr = destAddr[ADDR_W-1:LANE_W];
      wrData     = {LANES{regWrData[7:0]}};
      wrBe       = pixMask & laneSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destAddr  <= '0;
      stride    <= '0;
      pixMask   <= '1;
      wordMode  <= 1'b0;
      memWrEn   <= 1'b0;
      memAddr   <= '0;
      memWrData <= '0;
      memByteEn <= '0;
    end else begin
      memWrEn <= strobe.pixWr;
      if (strobe.ldDest)   destAddr <= regWrData[ADDR_W-1:0];
      if (strobe.ldMask)   pixMask  <= regWrData[LANES-1:0];
      if (strobe.ldMode)   wordMode <= regWrData[0];
      if (strobe.ldStride) stride   <= regWrData[ADDR_W-1:0];
      if (strobe.pixWr) begin
        destAddr  <= nextAddr;
        memAddr   <= wrWordAddr;
        memWrData <= wrData;
        memByteEn <= wrBe;
      end
    end
  end

endmodule

// File: rtl/pixstep_port.sv
module pixstep_port
  import pixstep_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 8,
  parameter int REG_AW  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic                memWrEn,
  output logic [WADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memByteEn
);

  ctrlStrobe_t strobe;

  pixstep_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  pixstep_dp #(.DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memByteEn (memByteEn)
  );

endmodule

// File: rtl/pixstep_chk.sv
module pixstep_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [REG_AW-1:0]   regAddr,
  input logic [DATA_W/8-1:0] cfgBits,
  input logic                memWrEn,
  input logic [DATA_W-1:0]   memWrData,
  input logic [DATA_W/8-1:0] memByteEn
);

  localparam int LANES = DATA_W / 8;

  logic             modeQ, modeD;
  logic [LANES-1:0] maskQ, maskD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      modeD <= 1'b0;
      maskQ <= '1;
      maskD <= '1;
    end else begin
      if (regWrEn && regAddr == REG_AW'(2)) modeQ <= cfgBits[0];
      if (regWrEn && regAddr == REG_AW'(1)) maskQ <= cfgBits;
      modeD <= modeQ;
      maskD <= maskQ;
    end
  end

  AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[REG_AW-1]) |=> memWrEn); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr[REG_AW-1]) |=> !memWrEn); // R10
  AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !modeD) |-> $onehot0(memByteEn)); // R4
  AST_BYTE_REPL: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !modeD) |-> (memWrData == {LANES{memWrData[7:0]}})); // R4
  AST_WORD_BE: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && modeD) |-> (memByteEn == maskD)); // R3

endmodule

bind pixstep_port pixstep_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .cfgBits   (regWrData[DATA_W/8-1:0]),
  .memWrEn   (memWrEn),
  .memWrData (memWrData),
  .memByteEn (memByteEn)
);

// File: tb/pixstep_port_tb.sv
module pixstep_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memWrEn;
  logic [7:0]  memAddr;
  logic [31:0] memWrData;
  logic [3:0]  memByteEn;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [9:0]  mDest = '0;
  logic [9:0]  mStride = '0;
  logic [3:0]  mMask = 4'hf;
  logic        mWord = 1'b0;
  logic [31:0] refMem [WORDS];
  logic [31:0] dutMem [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixstep_port u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memByteEn(memByteEn)
  );

  always @(posedge clk)
    if (memWrEn)
      for (int b = 0; b < 4; b++)
        if (memByteEn[b]) dutMem[memAddr][b*8 +: 8] <= memWrData[b*8 +: 8];

  function automatic logic [9:0] stepAddr(logic [9:0] a, logic [2:0] d,
                                          logic [9:0] s, logic w);
    logic [9:0] r;
    r = a;
    case (d)
      3'd0: r = a + 10'd1;
      3'd1: r = a - 10'd1;
      3'd2: r = a + s;
      3'd3: r = a - s;
      3'd4: r = a + 10'd1 + s;
      3'd5: r = a - 10'd1 + s;
      3'd6: r = a + 10'd1 - s;
      default: r = a - 10'd1 - s;
    endcase
    if (w) r[9:8] = 2'b00;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // one register write (or idle when en=0), then compare the memory port
  task automatic doOp(input bit en, input logic [3:0] a, input logic [31:0] d, input string tag);
    logic        eWr;
    logic [7:0]  eAddr;
    logic [31:0] eData;
    logic [3:0]  eBe;
    eWr = en && a[3];
    eAddr = '0; eData = '0; eBe = '0;
    if (eWr) begin
      if (mWord) begin
        eAddr = mDest[7:0]; eData = d; eBe = mMask;
      end else begin
        eAddr = mDest[9:2]; eData = {4{d[7:0]}};
        eBe = mMask & (4'b0001 << mDest[1:0]);
      end
      for (int b = 0; b < 4; b++)
        if (eBe[b]) refMem[eAddr][b*8 +: 8] = eData[b*8 +: 8];
      mDest = stepAddr(mDest, a[2:0], mStride, mWord);
    end else if (en) begin
      case (a)
        4'd0: mDest = d[9:0];
        4'd1: mMask = d[3:0];
        4'd2: mWord = d[0];
        4'd3: mStride = d[9:0];
        default: ;
      endcase
    end
    regWrEn = en; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    if (eWr)
      check(memWrEn && memAddr == eAddr && memWrData == eData && memByteEn == eBe, tag,
            $sformatf("wr=%0b addr=%0h data=%h be=%b", memWrEn, memAddr, memWrData, memByteEn),
            $sformatf("wr=1 addr=%0h data=%h be=%b", eAddr, eData, eBe));
    else
      check(!memWrEn, tag, $sformatf("wr=%0b", memWrEn), "wr=0");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R2: watchdog expired, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] rv;
    int mm;
    seed = $urandom(32'h5eed1234);
    for (int i = 0; i < WORDS; i++) begin refMem[i] = '0; dutMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset, defaults observed through first write
    check(!memWrEn, "R1 reset idle", $sformatf("wr=%0b", memWrEn), "wr=0");
    doOp(1, 4'd8, 32'h0000_00a5, "R1 default byte mode addr 0");
    // R5 horizontal steps in byte mode, R9 back to back
    doOp(1, 4'd8, 32'h11, "R5 right");
    doOp(1, 4'd8, 32'h22, "R9 back-to-back right");
    doOp(1, 4'd9, 32'h33, "R5 left");
    // R6 vertical with stride
    doOp(1, 4'd3, 32'd16, "R6 stride load");
    doOp(1, 4'd10, 32'h44, "R6 down");
    doOp(1, 4'd11, 32'h55, "R6 up");
    doOp(1, 4'd11, 32'h56, "R6 up again");
    // R7 diagonals
    doOp(1, 4'd0, 32'd200, "R7 dest load");
    for (int k = 12; k < 16; k++) doOp(1, 4'(k), 32'(k), "R7 diagonal");
    for (int k = 12; k < 16; k++) doOp(1, 4'(k), 32'(k + 16), "R7 diagonal repeat");
    // R4 byte mask gating
    doOp(1, 4'd1, 32'h5, "R4 mask load");
    for (int k = 0; k < 4; k++) doOp(1, 4'd8, 32'h60 + 32'(k), "R4 masked lanes");
    // R8 byte wrap
    doOp(1, 4'd0, 32'd1023, "R8 dest top");
    doOp(1, 4'd8, 32'h77, "R8 byte wrap up");
    doOp(1, 4'd9, 32'h78, "R8 at zero");
    doOp(1, 4'd9, 32'h79, "R8 byte wrap down");
    // R3 word mode
    doOp(1, 4'd2, 32'd1, "R3 mode load");
    doOp(1, 4'd1, 32'ha, "R3 mask load");
    doOp(1, 4'd0, 32'd255, "R8 dest word top");
    doOp(1, 4'd8, 32'hdead_beef, "R3 word write");
    doOp(1, 4'd8, 32'hcafe_f00d, "R8 word wrap");
    doOp(1, 4'd0, 32'd0, "R8 dest zero");
    doOp(1, 4'd15, 32'h1234_5678, "R8 word wrap diag");
    // R10 unused addresses
    for (int k = 4; k < 8; k++) doOp(1, 4'(k), 32'hffff_ffff, "R10 unused write");
    doOp(1, 4'd8, 32'h0bad_cafe, "R10 state untouched");
    doOp(0, 4'd8, 32'h0, "R2 idle no write");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      rv = $urandom;
      case (rv[2:0])
        3'd0: doOp(1, 4'(rv[5:4]), $urandom, "R2 random config");
        3'd1: doOp(rv[8], 4'(4 + rv[5:4]), $urandom, "R10 random unused/idle");
        default: doOp(1, {1'b1, rv[6:4]}, $urandom, "R9 random data");
      endcase
    end
    repeat (2) @(negedge clk);
    mm = 0;
    for (int i = 0; i < WORDS; i++) if (dutMem[i] !== refMem[i]) mm++;
    check(mm == 0, "R2 memory image", $sformatf("%0d words differ", mm), "0 words differ");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule